// File: doc/BRIEF.md
# Lagged-Carry Count Decoder

This block turns the raw state word of a free-running counter whose carries travel one bit position per clock into the plain binary count. In such a counter, bit k only learns about a carry k clocks after a ripple adder would have shown it. The raw word is therefore a fixed, invertible scramble of the true count. The decoder undoes the scramble with an ordered chain of compare-and-flip steps, one for each bit above bit 0.

Words enter and leave on valid/ready streams. The step chain can be cut into a chosen number of register stages, so that each clock period holds only a few steps. With zero stages the block is purely combinational. A stage holds its word while the downstream side is not ready. When ready is high it accepts a new word on every clock, so full throughput holds at any depth. Words leave in the order they arrived, and none is lost or repeated.

Top module: `lagcarry_decoder`

## Requirements
- R1: Input encoding. For a true count c, raw bit 0 is c[0]. For k >= 1, raw bit k is c[k] inverted exactly when (c mod 2^k) < k. The decoder returns c for every such raw word.
- R2: Output bit 0 always equals input bit 0 of the same word.
- R3: For any input word, the output is produced by visiting k = 1 up to WIDTH-1 in ascending order. At each step, bit k is inverted when the value of bits k-1..0 of the word, as already corrected by lower steps, is less than k. Bits never visited are unchanged.
- R4: While out_ready stays high, a word accepted on one clock appears on out_word exactly STAGES clocks later.
- R5: With STAGES = 0, out_valid equals in_valid, in_ready equals out_ready, and out_word is the decoded value in the same cycle.
- R6: Back-pressure. While out_valid is high and out_ready is low, out_valid stays high and out_word holds its value on the next clock. Words leave in the order they entered, with none lost or duplicated.
- R7: Whenever out_ready is high, in_ready is high.
- R8: rst is synchronous and active high. On the clock after rst is asserted, out_valid is low (STAGES >= 1).
- R9: Feeding the encoded counter state once per clock gives outputs that step by one and wrap from 2^WIDTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw word on in_word is offered |
| in_ready | output | 1 | Decoder accepts the offered word this clock |
| in_word | input | WIDTH | Raw counter state word |
| out_valid | output | 1 | Decoded word on out_word is offered |
| out_ready | input | 1 | Consumer takes the decoded word this clock |
| out_word | output | WIDTH | Decoded binary count |

## Verification
The assertions check on every cycle that each slice's output satisfies the compare-and-flip relation for the steps it owns, and that it leaves every other bit untouched, bit 0 included. They also check that a stalled stage holds both its valid flag and its word, that ready reaches the input whenever the consumer is ready, and that reset empties the stages.

Some properties need the bench's scenarios rather than a per-cycle check. Only the bench shows that the chain as a whole returns the true count and wraps correctly over a long counting run. It also sweeps every input word against an arithmetic model of the rule. Finally, it measures the exact latency and confirms in-order delivery under random stalls on both sides.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  // First correction step (inclusive) handled by pipeline stage s.
  function automatic int stage_lo(input int s, input int steps, input int stages);
    return 1 + (s * steps) / stages;
  endfunction

  // Last correction step (inclusive) handled by pipeline stage s.
  function automatic int stage_hi(input int s, input int steps, input int stages);
    return ((s + 1) * steps) / stages;
  endfunction

endpackage

// File: rtl/lcd_fix_slice.sv
// Applies correction steps LO..HI (ascending) to a word; combinational.
module lcd_fix_slice #(
  parameter int W  = 8,
  parameter int LO = 1,
  parameter int HI = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] fix_o
);

  function automatic logic [W-1:0] low_mask(input int k);
    logic [W-1:0] m;
    m = '0;
    for (int j = 0; j < W; j++) begin
      if (j < k) m[j] = 1'b1;
    end
    return m;
  endfunction

  always_comb begin
    logic [W-1:0] w;
    w = raw_i;
    for (int k = 1; k < W; k++) begin
      if (k >= LO && k <= HI) begin
        if ((w & low_mask(k)) < W'(k)) w[k] = ~w[k];
      end
    end
    fix_o = w;
  end

  // R2
  bit0_keep_chk: assert property (@(posedge clk) disable iff (rst)
    fix_o[0] == raw_i[0]);

  for (genvar k = 1; k < W; k++) begin : g_chk
    localparam logic [W-1:0] LMASK = (W'(1) << k) - W'(1);
    if (k >= LO && k <= HI) begin : g_own
      // R3
      step_rule_chk: assert property (@(posedge clk) disable iff (rst)
        ((fix_o & LMASK) < W'(k)) == (fix_o[k] != raw_i[k]));
    end else begin : g_other
      // R3
      step_skip_chk: assert property (@(posedge clk) disable iff (rst)
        fix_o[k] == raw_i[k]);
    end
  end

endmodule

// File: rtl/lcd_pipe_reg.sv
// One valid/ready register stage.
module lcd_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic         vq;
  logic [W-1:0] dq;
  logic         load;

  assign load     = ~vq | dn_ready;
  assign up_ready = load;
  assign dn_valid = vq;
  assign dn_data  = dq;

  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= 1'b0;
      dq <= '0;
    end else if (load) begin
      vq <= up_valid;
      if (up_valid) dq <= up_data;
    end
  end

  // R6
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> dn_valid);

  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> $stable(dn_data));

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !dn_valid);

endmodule

// File: rtl/lagcarry_decoder.sv
// Decodes the state word of a carry-per-clock counter into binary.
module lagcarry_decoder #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_word
);

  localparam int STEPS = WIDTH - 1;

  if (STAGES == 0) begin : g_comb
    lcd_fix_slice #(.W(WIDTH), .LO(1), .HI(STEPS)) u_slice (
      .clk   (clk),
      .rst   (rst),
      .raw_i (in_word),
      .fix_o (out_word)
    );
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
  end else begin : g_pipe
    logic [WIDTH-1:0] st_word [0:STAGES];
    logic             st_valid [0:STAGES];
    logic             st_ready [0:STAGES];

    assign st_word[0]      = in_word;
    assign st_valid[0]     = in_valid;
    assign in_ready        = st_ready[0];
    assign out_word        = st_word[STAGES];
    assign out_valid       = st_valid[STAGES];
    assign st_ready[STAGES] = out_ready;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int LO = lcd_pkg::stage_lo(s, STEPS, STAGES);
      localparam int HI = lcd_pkg::stage_hi(s, STEPS, STAGES);
      logic [WIDTH-1:0] fixed;

      lcd_fix_slice #(.W(WIDTH), .LO(LO), .HI(HI)) u_slice (
        .clk   (clk),
        .rst   (rst),
        .raw_i (st_word[s]),
        .fix_o (fixed)
      );

      lcd_pipe_reg #(.W(WIDTH)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .up_valid (st_valid[s]),
        .up_ready (st_ready[s]),
        .up_data  (fixed),
        .dn_valid (st_valid[s+1]),
        .dn_ready (st_ready[s+1]),
        .dn_data  (st_word[s+1])
      );
    end
  end

  // R7
  ready_reach_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

endmodule

// File: tb/tb_lagcarry_decoder.sv
module tb_lagcarry_decoder;
  localparam int W  = 6;
  localparam int ST = 2;
  localparam int P1 = 200;
  localparam int NI = P1 + 64 + 200;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst, in_valid, out_ready;
  logic [W-1:0] in_word;
  logic         in_ready, out_valid;
  logic [W-1:0] out_word;
  logic         c_in_ready, c_out_valid;
  logic [W-1:0] c_out_word;

  lagcarry_decoder #(.WIDTH(W), .STAGES(ST)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word));

  lagcarry_decoder #(.WIDTH(W), .STAGES(0)) dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_word(in_word), .out_valid(c_out_valid), .out_ready(out_ready),
    .out_word(c_out_word));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] it_in  [NI];
  logic [W-1:0] it_exp [NI];
  int           acc_cyc[NI];

  // Counter state for true count c (R1 encoding).
  function automatic logic [W-1:0] enc(input int c);
    int v = c % (1 << W);
    int r = v;
    for (int k = 1; k < W; k++)
      if ((v & ((1 << k) - 1)) < k) r = r ^ (1 << k);
    return W'(r);
  endfunction

  // Ascending compare-and-flip model (R3).
  function automatic logic [W-1:0] rule(input logic [W-1:0] w);
    int v = int'(w);
    for (int k = 1; k < W; k++)
      if ((v & ((1 << k) - 1)) < k) v = v ^ (1 << k);
    return W'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(60000 * 20);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int sent = 0;
    int rcv = 0;
    int cyc = 0;
    logic [15:0] lf = 16'hACE1;
    bit prev_stall = 1'b0;
    logic [W-1:0] prev_word = '0;

    for (int i = 0; i < P1; i++) begin
      it_in[i] = enc(i);
      it_exp[i] = W'(i % (1 << W));
    end
    for (int i = 0; i < 64; i++) begin
      it_in[P1+i] = W'(i);
      it_exp[P1+i] = rule(W'(i));
    end
    for (int i = 0; i < 200; i++) begin
      it_in[P1+64+i] = enc(i * 7 + 3);
      it_exp[P1+64+i] = W'((i * 7 + 3) % (1 << W));
    end

    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    #1;
    // R8: reset leaves the pipeline empty
    chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;

    while (rcv < NI && !done) begin
      @(negedge clk);
      in_valid  = (sent < NI) && ((sent < P1) || lf[0] || lf[3]);
      out_ready = (rcv < P1) || (sent >= NI) || lf[5] || lf[9];
      in_word   = (sent < NI) ? it_in[sent] : '0;
      #1;
      if (prev_stall) begin
        // R6: stalled output holds
        chk(out_valid && out_word == prev_word, "R6", int'(out_word), int'(prev_word));
      end
      prev_stall = out_valid && !out_ready;
      prev_word  = out_word;

      // R5: combinational variant
      chk(c_out_valid == in_valid && c_in_ready == out_ready, "R5",
          int'(c_out_valid), int'(in_valid));
      if (in_valid)
        chk(c_out_word == it_exp[sent], "R5", int'(c_out_word), int'(it_exp[sent]));

      // R7
      if (out_ready) chk(in_ready, "R7", int'(in_ready), 1);

      if (out_valid && out_ready) begin
        if (rcv < P1) begin
          chk(out_word == it_exp[rcv], "R1 R9", int'(out_word), int'(it_exp[rcv]));
          chk(cyc - acc_cyc[rcv] == ST, "R4", cyc - acc_cyc[rcv], ST);
        end else if (rcv < P1 + 64) begin
          chk(out_word == it_exp[rcv], "R3", int'(out_word), int'(it_exp[rcv]));
        end else begin
          chk(out_word == it_exp[rcv], "R6 order", int'(out_word), int'(it_exp[rcv]));
        end
        // R2
        chk(out_word[0] == it_in[rcv][0], "R2", int'(out_word[0]), int'(it_in[rcv][0]));
        rcv++;
      end
      if (in_valid && in_ready) begin
        acc_cyc[sent] = cyc;
        sent++;
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc++;
    end

    // R8: reset mid-run empties the stages
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0; in_word = enc(5);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R8", int'(out_valid), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule